// File: doc/BRIEF.md
# Delayed-Branch Fetch and Decode Front End

This block is the first two stages of a small in-order pipeline. The fetch stage holds the program counter and presents it to an instruction memory, which returns one fixed-width 32-bit word in the same cycle. That word is captured into a decode register at the next edge. While it sits there, its register index fields are sent to an external register file and its opcode is decoded in parallel. The read data is used by the branch logic in the same cycle. A read that the instruction does not need costs nothing and is simply ignored downstream.

Conditional branches compare one register with zero, so they resolve in decode. The word fetched while a branch is decoded is its delay slot, and it always follows the branch into decode. Fetch is then steered to the target, so no flush is needed. A branch may set its annul bit. When that bit is set and the branch falls through, the slot becomes a bubble. A stall input from later stages freezes both the program counter and the decode register.

Top module: `slot_fetch_decode`

## Requirements
- R1: While `rst_ni` is low, `imem_addr_o` equals `RESET_PC` and `dec_valid_o` is 0.
- R2: With no stall and no taken branch, the fetch address grows by 4 every cycle. The word fetched at address A reaches decode one cycle later with `dec_pc_o` = A and `dec_valid_o` = 1.
- R3: The decoded fields are taken from the word in the decode register as follows. Opcode is bits 31:26 and destination index is bits 15:11. The immediate is bits 15:0, sign-extended to 32 bits.
- R4: `rs_addr_o` is bits 25:21 and `rt_addr_o` is bits 20:16 of the decoded word. Both are driven in the decode cycle whether or not the opcode uses them.
- R5: Opcodes 0x04, 0x05, 0x06 and 0x07 are branches on the value `rs_data_i`: taken when it is zero, nonzero, negative (bit 31 set) and non-negative respectively. `dec_br_taken_o` reports the outcome, and `dec_is_branch_o` marks these four opcodes.
- R6: A taken branch makes the next fetch address `dec_pc_o` + 4 + (sign-extended bits 15:0 shifted left by 2), modulo 2^ADDR_W. A branch that is not taken leaves the fetch address at the current fetch address plus 4.
- R7: The word at the branch address plus 4 (the delay slot) always enters decode in the cycle after the branch. The word after it is the target if the branch was taken, or the next sequential word if not.
- R8: Bit 20 of a branch word is its annul bit. If the annul bit is set and the branch is not taken, the slot's `dec_valid_o` is 0. If it is taken, or the bit is clear, the slot is valid.
- R9: While `stall_i` is high, `imem_addr_o` and all decode outputs hold their values, and `next_pc_o` equals `imem_addr_o`. On release, decoding resumes with no instruction lost, including a pending delay slot.
- R10: A bubble in decode (`dec_valid_o` = 0) never redirects fetch, even if its bits form a branch whose condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Freeze request from later stages |
| imem_addr_o | output | ADDR_W | Current fetch address |
| imem_rdata_i | input | 32 | Instruction word at `imem_addr_o` |
| rs_addr_o | output | 5 | First register read index |
| rt_addr_o | output | 5 | Second register read index |
| rs_data_i | input | 32 | Register file data for `rs_addr_o` |
| dec_valid_o | output | 1 | Decode slot holds a live instruction |
| dec_pc_o | output | ADDR_W | Address of the decoded instruction |
| dec_op_o | output | 6 | Decoded opcode |
| dec_rd_o | output | 5 | Destination register index |
| dec_imm_o | output | 32 | Sign-extended immediate |
| dec_is_branch_o | output | 1 | Decoded word is a branch opcode |
| dec_br_taken_o | output | 1 | Live branch in decode is taken |
| next_pc_o | output | ADDR_W | Fetch address for the next cycle |

## Verification
The bench builds the block with ADDR_W = 12 and RESET_PC = 0x100. A 64-word instruction window and a modelled register file then cover every program the tests run. The narrow address makes backward offsets wrap below zero, which exercises the modulo rule of the target sum. The bench sweeps all four branch conditions across zero, one, all-ones, the most negative and the most positive values, with and without the annul bit, and over three offsets. A bubble holding a true branch, a stall held across a pending delay slot, and a set of mixed field patterns complete the coverage.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned ANNUL_BIT = 20;

  localparam logic [OP_W-1:0] OP_BR_EQZ = 6'h04;
  localparam logic [OP_W-1:0] OP_BR_NEZ = 6'h05;
  localparam logic [OP_W-1:0] OP_BR_LTZ = 6'h06;
  localparam logic [OP_W-1:0] OP_BR_GEZ = 6'h07;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rd;
    logic [IMM_W-1:0] imm;
    logic             annul;
  } fields_t;

  function automatic fields_t split_word(logic [INSN_W-1:0] w);
    fields_t f;
    f.op    = w[31:26];
    f.rs    = w[25:21];
    f.rt    = w[20:16];
    f.rd    = w[15:11];
    f.imm   = w[15:0];
    f.annul = w[ANNUL_BIT];
    return f;
  endfunction
endpackage

// File: rtl/sfd_fetch.sv
module sfd_fetch #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q;

  always_comb begin
    if (stall_i)         next_pc_o = pc_q;
    else if (redirect_i) next_pc_o = target_i;
    else                 next_pc_o = pc_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !redirect_i) |=> pc_q == $past(pc_q) + STEP);
endmodule

// File: rtl/sfd_decode.sv
module sfd_decode #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       stall_i,
  input  logic                       kill_i,
  input  logic [sfd_pkg::INSN_W-1:0] insn_i,
  input  logic [ADDR_W-1:0]          pc_i,
  output logic                       valid_o,
  output logic [sfd_pkg::INSN_W-1:0] insn_o,
  output logic [ADDR_W-1:0]          pc_o
);
  logic                       valid_q;
  logic [sfd_pkg::INSN_W-1:0] insn_q;
  logic [ADDR_W-1:0]          pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      insn_q  <= '0;
      pc_q    <= '0;
    end else if (!stall_i) begin
      valid_q <= !kill_i;
      insn_q  <= insn_i;
      pc_q    <= pc_i;
    end
  end

  assign valid_o = valid_q;
  assign insn_o  = insn_q;
  assign pc_o    = pc_q;

  a_r9_hold_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(insn_q) && $stable(pc_q) && $stable(valid_q));
endmodule

// File: rtl/sfd_branch.sv
module sfd_branch #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                        valid_i,
  input  logic [sfd_pkg::OP_W-1:0]    op_i,
  input  logic [sfd_pkg::IMM_W-1:0]   imm_i,
  input  logic                        annul_i,
  input  logic [ADDR_W-1:0]           pc_i,
  input  logic [sfd_pkg::INSN_W-1:0]  rs_val_i,
  output logic                        is_branch_o,
  output logic                        taken_o,
  output logic                        kill_slot_o,
  output logic [ADDR_W-1:0]           target_o
);
  import sfd_pkg::*;

  logic        cond;
  logic [31:0] off32;

  always_comb begin
    is_branch_o = 1'b1;
    cond        = 1'b0;
    unique case (op_i)
      OP_BR_EQZ: cond = (rs_val_i == '0);
      OP_BR_NEZ: cond = (rs_val_i != '0);
      OP_BR_LTZ: cond = rs_val_i[INSN_W-1];
      OP_BR_GEZ: cond = !rs_val_i[INSN_W-1];
      default:   is_branch_o = 1'b0;
    endcase
  end

  assign taken_o     = valid_i && is_branch_o && cond;
  assign kill_slot_o = valid_i && is_branch_o && annul_i && !cond;

  // Offset counts words from the delay slot address.
  assign off32    = {{(32-IMM_W-2){imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = pc_i + ADDR_W'(4) + off32[ADDR_W-1:0];
endmodule

// File: rtl/slot_fetch_decode.sv
module slot_fetch_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [31:0]       imem_rdata_i,
  output logic [4:0]        rs_addr_o,
  output logic [4:0]        rt_addr_o,
  input  logic [31:0]       rs_data_i,
  output logic              dec_valid_o,
  output logic [ADDR_W-1:0] dec_pc_o,
  output logic [5:0]        dec_op_o,
  output logic [4:0]        dec_rd_o,
  output logic [31:0]       dec_imm_o,
  output logic              dec_is_branch_o,
  output logic              dec_br_taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  import sfd_pkg::*;

  logic              redirect, kill_slot, dec_valid;
  logic [ADDR_W-1:0] target, fetch_pc, dec_pc;
  logic [INSN_W-1:0] dec_word;
  fields_t           f;

  sfd_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk_i, .rst_ni, .stall_i,
    .redirect_i(redirect), .target_i(target),
    .pc_o(fetch_pc), .next_pc_o(next_pc_o)
  );

  sfd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i, .rst_ni, .stall_i,
    .kill_i(kill_slot), .insn_i(imem_rdata_i), .pc_i(fetch_pc),
    .valid_o(dec_valid), .insn_o(dec_word), .pc_o(dec_pc)
  );

  assign f = split_word(dec_word);

  sfd_branch #(.ADDR_W(ADDR_W)) u_branch (
    .valid_i(dec_valid), .op_i(f.op), .imm_i(f.imm), .annul_i(f.annul),
    .pc_i(dec_pc), .rs_val_i(rs_data_i),
    .is_branch_o(dec_is_branch_o), .taken_o(redirect),
    .kill_slot_o(kill_slot), .target_o(target)
  );

  assign imem_addr_o    = fetch_pc;
  assign rs_addr_o      = f.rs;
  assign rt_addr_o      = f.rt;
  assign dec_valid_o    = dec_valid;
  assign dec_pc_o       = dec_pc;
  assign dec_op_o       = f.op;
  assign dec_rd_o       = f.rd;
  assign dec_imm_o      = {{(INSN_W-IMM_W){f.imm[IMM_W-1]}}, f.imm};
  assign dec_br_taken_o = redirect;

  a_r6_target_fetched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && redirect) |=> fetch_pc == $past(target));

  a_r7_slot_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dec_valid && dec_is_branch_o && !f.annul)
      |=> dec_valid && dec_pc == $past(dec_pc) + ADDR_W'(4));

  a_r8_annul_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dec_valid && dec_is_branch_o && f.annul && !redirect)
      |=> !dec_valid);

  a_r10_bubble_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_valid && !stall_i) |-> next_pc_o == fetch_pc + ADDR_W'(4));

  a_r9_stall_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(fetch_pc));
endmodule

// File: tb/slot_fetch_decode_tb.sv
module slot_fetch_decode_tb;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] RESET_PC = 12'h100;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              stall_i = 1'b0;
  logic [ADDR_W-1:0] imem_addr_o, dec_pc_o, next_pc_o;
  logic [31:0]       imem_rdata_i, rs_data_i, dec_imm_o;
  logic [4:0]        rs_addr_o, rt_addr_o, dec_rd_o;
  logic [5:0]        dec_op_o;
  logic              dec_valid_o, dec_is_branch_o, dec_br_taken_o;

  logic [31:0] mem  [64];
  logic [31:0] regs [32];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata_i = mem[imem_addr_o[7:2]];
  assign rs_data_i    = regs[rs_addr_o];

  slot_fetch_decode #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dut (
    .clk_i(clk), .rst_ni, .stall_i, .imem_addr_o, .imem_rdata_i,
    .rs_addr_o, .rt_addr_o, .rs_data_i, .dec_valid_o, .dec_pc_o,
    .dec_op_o, .dec_rd_o, .dec_imm_o, .dec_is_branch_o, .dec_br_taken_o,
    .next_pc_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++)
      mem[i] = {6'h01, 5'd1, 5'd2, 5'(i), 11'(i)};
    for (int i = 0; i < 32; i++) regs[i] = 32'(i) * 32'h01010101;
    regs[0] = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    stall_i = 1'b0;
    tick(); tick();
    chk(imem_addr_o == RESET_PC, "R1 addr", 32'(imem_addr_o), 32'(RESET_PC));
    chk(dec_valid_o == 1'b0, "R1 valid", 32'(dec_valid_o), 32'd0);
    rst_ni = 1'b1;
  endtask

  function automatic bit br_cond(logic [5:0] op, logic [31:0] v);
    case (op)
      6'h04: return v == 0;
      6'h05: return v != 0;
      6'h06: return v[31];
      default: return !v[31];
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [5];
    int          offs [3];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF;
    offs[0] = 3; offs[1] = -1; offs[2] = -100;

    // R1, R2: sequential stream
    fill();
    do_reset();
    for (int n = 0; n < 6; n++) begin
      tick();
      chk(dec_valid_o == 1'b1, "R2 valid", 32'(dec_valid_o), 32'd1);
      chk(dec_pc_o == RESET_PC + 12'(4*n), "R2 dec_pc", 32'(dec_pc_o),
          32'(RESET_PC + 12'(4*n)));
      chk(dec_rd_o == 5'(n), "R2 word", 32'(dec_rd_o), 32'(n));
      chk(imem_addr_o == RESET_PC + 12'(4*n + 4), "R2 fetch",
          32'(imem_addr_o), 32'(RESET_PC + 12'(4*n + 4)));
    end

    // R3, R4: field extraction
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      logic [5:0]  op;
      fill();
      w = 32'h9E37_79B9 * 32'(k + 1) ^ 32'(k << 15);
      mem[0] = w;
      op = w[31:26];
      do_reset();
      tick();
      chk(dec_op_o == w[31:26], "R3 op", 32'(dec_op_o), 32'(w[31:26]));
      chk(dec_rd_o == w[15:11], "R3 rd", 32'(dec_rd_o), 32'(w[15:11]));
      chk(dec_imm_o == {{16{w[15]}}, w[15:0]}, "R3 imm", dec_imm_o,
          {{16{w[15]}}, w[15:0]});
      chk(rs_addr_o == w[25:21], "R4 rs", 32'(rs_addr_o), 32'(w[25:21]));
      chk(rt_addr_o == w[20:16], "R4 rt", 32'(rt_addr_o), 32'(w[20:16]));
      chk(dec_is_branch_o == (op >= 6'h04 && op <= 6'h07), "R5 is_branch",
          32'(dec_is_branch_o), 32'(op >= 6'h04 && op <= 6'h07));
    end

    // R5-R8: branch sweep
    for (int o = 4; o < 8; o++)
      for (int vi = 0; vi < 5; vi++)
        for (int an = 0; an < 2; an++)
          for (int fi = 0; fi < 3; fi++) begin
            bit          tk;
            logic [ADDR_W-1:0] tgt, nxt;
            fill();
            regs[5] = vals[vi];
            mem[0]  = {6'(o), 5'd5, 1'(an), 4'b0, 16'(offs[fi])};
            tk  = br_cond(6'(o), vals[vi]);
            tgt = RESET_PC + 12'd4 + 12'(offs[fi] * 4);
            nxt = tk ? tgt : RESET_PC + 12'd8;
            do_reset();
            tick();
            chk(dec_br_taken_o == tk, "R5 taken", 32'(dec_br_taken_o), 32'(tk));
            chk(next_pc_o == nxt, "R6 next_pc", 32'(next_pc_o), 32'(nxt));
            tick();
            chk(dec_pc_o == RESET_PC + 12'd4, "R7 slot pc", 32'(dec_pc_o),
                32'(RESET_PC + 12'd4));
            chk(dec_valid_o == !(an == 1 && !tk), "R8 slot valid",
                32'(dec_valid_o), 32'(!(an == 1 && !tk)));
            chk(imem_addr_o == nxt, "R6 fetch", 32'(imem_addr_o), 32'(nxt));
            tick();
            chk(dec_pc_o == nxt && dec_valid_o, "R7 after slot",
                32'(dec_pc_o), 32'(nxt));
          end

    // R10: annulled slot holding a true branch must not redirect
    fill();
    regs[5] = 32'h0;
    mem[0] = {6'h05, 5'd5, 1'b1, 4'b0, 16'd7};
    mem[1] = {6'h04, 5'd0, 5'd0, 16'd20};
    do_reset();
    tick(); tick();
    chk(dec_valid_o == 1'b0, "R10 bubble", 32'(dec_valid_o), 32'd0);
    chk(dec_br_taken_o == 1'b0, "R10 taken", 32'(dec_br_taken_o), 32'd0);
    chk(next_pc_o == RESET_PC + 12'd12, "R10 next_pc", 32'(next_pc_o),
        32'(RESET_PC + 12'd12));

    // R9: stall while a taken branch waits in decode
    fill();
    regs[5] = 32'h0;
    mem[0] = {6'h04, 5'd5, 5'd0, 16'd5};
    do_reset();
    tick();
    stall_i = 1'b1;
    for (int s = 0; s < 3; s++) begin
      tick();
      chk(dec_pc_o == RESET_PC && dec_valid_o, "R9 hold dec", 32'(dec_pc_o),
          32'(RESET_PC));
      chk(imem_addr_o == RESET_PC + 12'd4, "R9 hold fetch", 32'(imem_addr_o),
          32'(RESET_PC + 12'd4));
      chk(next_pc_o == imem_addr_o, "R9 next_pc", 32'(next_pc_o),
          32'(imem_addr_o));
    end
    stall_i = 1'b0;
    tick();
    chk(dec_pc_o == RESET_PC + 12'd4 && dec_valid_o, "R9 slot kept",
        32'(dec_pc_o), 32'(RESET_PC + 12'd4));
    chk(dec_rd_o == 5'd1, "R9 slot word", 32'(dec_rd_o), 32'd1);
    chk(imem_addr_o == RESET_PC + 12'd24, "R9 target", 32'(imem_addr_o),
        32'(RESET_PC + 12'd24));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule